// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This unit holds the status word that a serial port presents to software and reduces it to one interrupt bit for the system status register. It keeps three event flags that the receive and transmit paths set and that the CPU clears: receive data ready, transmit holding empty and receive shift full. It also keeps two latched modem-line flags, one for CTS and one for DCD. The live levels of both lines appear in the status word as well.

Each modem-line flag is level-sensitive. A polarity bit picks which level counts as the interrupt condition. Once set, the flag stays latched until software writes the acknowledge strobe with the matching bit. If the line still meets the condition on that cycle, the flag stays set. To clear it for good, software first flips the polarity and then acknowledges. A mask register selects which flags drive the interrupt bit. The mask has no effect on the status word.

Every flag is a two-state machine. An event flag has the states EV_CLEAR and EV_SET. Its transitions are `set` (EV_CLEAR to EV_SET, on its set pulse) and `drop` (EV_SET to EV_CLEAR, on its clear strobe with no set pulse in the same cycle). A line flag has the states LN_QUIET and LN_LATCHED. Its transitions are `trip` (LN_QUIET to LN_LATCHED, when the line meets the polarity condition) and `release` (LN_LATCHED to LN_QUIET, on an acknowledge while the condition is false). In every other case the state holds.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the mask is zero, `irq_out` is 0, and the status word holds only bit 4 (transmit empty) plus the live line bits.
- R2: The status word has this layout: bit 7 receive-shift-full, bit 6 DCD flag, bit 5 CTS flag, bit 4 transmit-empty, bit 3 always 0, bit 2 receive-ready, bit 1 live `dcd_in`, bit 0 live `cts_in`. The two live bits follow the pins with no clock delay.
- R3: Bit 2 is set on the clock after `rx_full_set`. It is cleared on the clock after `rx_data_rd`, unless `rx_full_set` is also high on that cycle, in which case the set wins.
- R4: Bit 4 is set on the clock after `tx_empty_set`. It is cleared on the clock after `tx_data_wr`, with the set winning if both are high.
- R5: Bit 7 is set on the clock after `rx_shift_set`. It is cleared on the clock after a `status_rd` strobe, with the set winning if both are high.
- R6: A line flag sets on the clock after its line meets its condition. The condition is line low when the polarity input is 1, and line high when it is 0. DCD pairs with `dcd_pol_low` and CTS pairs with `cts_pol_low`.
- R7: A set line flag stays set after the line leaves the condition, until it is acknowledged.
- R8: `ack_wr` with `ack_wdata` bit 6 clears the DCD flag, and with bit 5 clears the CTS flag, on the next clock. Other acknowledge bits have no effect. If the condition still holds on the acknowledge cycle, the flag stays set.
- R9: `mask_wr` stores `mask_wdata` bits 6, 5, 4 and 2; the other bits store as 0. `irq_out` is the OR of (status AND mask) and follows the status with no clock delay.
- R10: The status flags update in the same way whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_in | input | 1 | CTS line level |
| dcd_in | input | 1 | DCD line level |
| cts_pol_low | input | 1 | 1: CTS condition is low level |
| dcd_pol_low | input | 1 | 1: DCD condition is low level |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_wdata | input | 8 | Acknowledge write data |
| status_rd | input | 1 | Status read strobe; clears bit 7 |
| rx_full_set | input | 1 | Receiver pulse: data ready |
| rx_data_rd | input | 1 | Receive data register read strobe |
| tx_empty_set | input | 1 | Transmitter pulse: holding register empty |
| tx_data_wr | input | 1 | Transmit data register write strobe |
| rx_shift_set | input | 1 | Receiver pulse: shift register full |
| status_out | output | 8 | Status word |
| irq_out | output | 1 | Masked interrupt bit |

## Verification
Two kinds of collision can fall on the same clock: a flag's set and its clear, and a line flag's acknowledge and a line level that still meets its condition. The random phase raises every set pulse and clear strobe with high probability, so set and clear often land together. Directed cases also hold a line in its condition while acknowledging it. A bench model that lets the set win in both kinds of collision judges the result one clock later, through the status bits and `irq_out`.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int STAT_W      = 8;
    localparam int NUM_EVENTS  = 3;
    localparam int NUM_LINES   = 2;

    localparam int BIT_SHIFT   = 7;
    localparam int BIT_DCD_IRQ = 6;
    localparam int BIT_CTS_IRQ = 5;
    localparam int BIT_TXE     = 4;
    localparam int BIT_RXR     = 2;
    localparam int BIT_DCD_LIV = 1;
    localparam int BIT_CTS_LIV = 0;

    localparam logic [STAT_W-1:0] MASK_USED =
        STAT_W'((1 << BIT_DCD_IRQ) | (1 << BIT_CTS_IRQ) | (1 << BIT_TXE) | (1 << BIT_RXR));

    typedef enum logic { EV_CLEAR, EV_SET } ev_state_t;
    typedef enum logic { LN_QUIET, LN_LATCHED } ln_state_t;

    // event index -> status bit position
    function automatic int ev_pos(input int idx);
        case (idx)
            0:       return BIT_RXR;
            1:       return BIT_TXE;
            default: return BIT_SHIFT;
        endcase
    endfunction

    // line index -> status / acknowledge bit position
    function automatic int ln_pos(input int idx);
        return (idx == 0) ? BIT_CTS_IRQ : BIT_DCD_IRQ;
    endfunction
endpackage

// File: rtl/uirq_event_flag.sv
module uirq_event_flag
    import uirq_pkg::*;
#(
    parameter bit RESET_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    localparam ev_state_t RST_STATE = RESET_SET ? EV_SET : EV_CLEAR;

    ev_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_CLEAR: if (set_i)           state_d = EV_SET;
            EV_SET:   if (clr_i && !set_i) state_d = EV_CLEAR;
            default:                       state_d = RST_STATE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == EV_SET);
    end

    // R3 R4 R5
    ev_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R3 R4 R5
    ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/uirq_line_flag.sv
module uirq_line_flag
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic pol_low_i,
    input  logic ack_i,
    output logic flag_o
);
    ln_state_t state_q, state_d;
    logic      cond;

    always_comb begin
        cond = pol_low_i ? !line_i : line_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_QUIET:   if (cond)           state_d = LN_LATCHED;
            LN_LATCHED: if (ack_i && !cond) state_d = LN_QUIET;
            default:                        state_d = LN_QUIET;
        endcase
    end

    always_comb begin
        flag_o = (state_q == LN_LATCHED);
    end

    // R6
    ln_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond |=> flag_o);
    // R7
    ln_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !ack_i) |=> flag_o);
    // R8
    ln_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !cond) |=> !flag_o);
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_in,
    input  logic              dcd_in,
    input  logic              cts_pol_low,
    input  logic              dcd_pol_low,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              ack_wr,
    input  logic [STAT_W-1:0] ack_wdata,
    input  logic              status_rd,
    input  logic              rx_full_set,
    input  logic              rx_data_rd,
    input  logic              tx_empty_set,
    input  logic              tx_data_wr,
    input  logic              rx_shift_set,
    output logic [STAT_W-1:0] status_out,
    output logic              irq_out
);
    logic [NUM_EVENTS-1:0] ev_set, ev_clr, ev_flag;
    logic [NUM_LINES-1:0]  ln_lvl, ln_pol, ln_flag;
    logic [STAT_W-1:0]     mask_q;

    assign ev_set = {rx_shift_set, tx_empty_set, rx_full_set};
    assign ev_clr = {status_rd,    tx_data_wr,   rx_data_rd};
    assign ln_lvl = {dcd_in, cts_in};
    assign ln_pol = {dcd_pol_low, cts_pol_low};

    for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_ev
        uirq_event_flag #(.RESET_SET(ev_pos(e) == BIT_TXE)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ev_set[e]),
            .clr_i  (ev_clr[e]),
            .flag_o (ev_flag[e])
        );
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_ln
        localparam logic [STAT_W-1:0] ACK_SEL = STAT_W'(1 << ln_pos(l));
        logic ack_hit;
        assign ack_hit = ack_wr && ((ack_wdata & ACK_SEL) != '0);
        uirq_line_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_i    (ln_lvl[l]),
            .pol_low_i (ln_pol[l]),
            .ack_i     (ack_hit),
            .flag_o    (ln_flag[l])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata & MASK_USED;
    end

    always_comb begin
        status_out              = '0;
        status_out[BIT_SHIFT]   = ev_flag[2];
        status_out[BIT_TXE]     = ev_flag[1];
        status_out[BIT_RXR]     = ev_flag[0];
        status_out[BIT_CTS_IRQ] = ln_flag[0];
        status_out[BIT_DCD_IRQ] = ln_flag[1];
        status_out[BIT_DCD_LIV] = dcd_in;
        status_out[BIT_CTS_LIV] = cts_in;
        irq_out                 = |(status_out & mask_q);
    end

    // R9
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == ($past(mask_wdata) & MASK_USED)));
    // R9
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (mask_q != '0));
endmodule

// File: tb/uart_irq_status_test.sv
`timescale 1ns/1ps
module uart_irq_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_in = 0, dcd_in = 0, cts_pol_low = 0, dcd_pol_low = 0;
    logic mask_wr = 0, ack_wr = 0, status_rd = 0;
    logic [7:0] mask_wdata = 0, ack_wdata = 0;
    logic rx_full_set = 0, rx_data_rd = 0, tx_empty_set = 0, tx_data_wr = 0, rx_shift_set = 0;
    logic [7:0] status_out;
    logic irq_out;

    int checks = 0, fails = 0;
    bit m_rxr, m_txe, m_shf, m_cts, m_dcd;
    logic [7:0] m_mask;

    always #10 clk = ~clk;

    uart_irq_status uut (.*);

    function automatic logic [7:0] exp_status();
        return {m_shf, m_dcd, m_cts, m_txe, 1'b0, m_rxr, dcd_in, cts_in};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [7:0] e;
        e = exp_status();
        chk("R5 bit7",    {7'd0, status_out[7]}, {7'd0, e[7]});
        chk("R6 R8 dcd",  {7'd0, status_out[6]}, {7'd0, e[6]});
        chk("R6 R8 cts",  {7'd0, status_out[5]}, {7'd0, e[5]});
        chk("R4 bit4",    {7'd0, status_out[4]}, {7'd0, e[4]});
        chk("R3 bit2",    {7'd0, status_out[2]}, {7'd0, e[2]});
        chk("R2 layout",  {4'd0, status_out[3], 1'b0, status_out[1:0]}, {4'd0, e[3], 1'b0, e[1:0]});
        chk("R9 irq",     {7'd0, irq_out}, {7'd0, |(e & m_mask)});
    endtask

    // model update from the requirements, using inputs present before the edge
    task automatic model_edge();
        bit cc, cd;
        cc = cts_pol_low ? !cts_in : cts_in;
        cd = dcd_pol_low ? !dcd_in : dcd_in;
        m_rxr = rx_full_set  ? 1'b1 : (rx_data_rd ? 1'b0 : m_rxr);
        m_txe = tx_empty_set ? 1'b1 : (tx_data_wr ? 1'b0 : m_txe);
        m_shf = rx_shift_set ? 1'b1 : (status_rd  ? 1'b0 : m_shf);
        m_cts = cc ? 1'b1 : ((ack_wr && ack_wdata[5]) ? 1'b0 : m_cts);
        m_dcd = cd ? 1'b1 : ((ack_wr && ack_wdata[6]) ? 1'b0 : m_dcd);
        if (mask_wr) m_mask = mask_wdata & 8'h74;
    endtask

    task automatic idle_inputs();
        mask_wr = 0; ack_wr = 0; status_rd = 0; ack_wdata = 0; mask_wdata = 0;
        rx_full_set = 0; rx_data_rd = 0; tx_empty_set = 0; tx_data_wr = 0; rx_shift_set = 0;
    endtask

    // inputs are set at the negedge already; check, clock, update model
    task automatic step();
        #1 check_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240613));
        m_rxr = 0; m_txe = 1; m_shf = 0; m_cts = 0; m_dcd = 0; m_mask = 0;
        repeat (3) @(negedge clk);
        // R1: reset state while held in reset
        #1 chk("R1 status", status_out, 8'h10);
        chk("R1 irq", {7'd0, irq_out}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        step();

        // R10: flags update with mask all zero
        rx_full_set = 1; rx_shift_set = 1; step(); idle_inputs();
        #1 chk("R10 flags set with mask 0", status_out & 8'h84, 8'h84);
        chk("R10 irq quiet", {7'd0, irq_out}, 8'h00);
        step();

        // R3/R4/R5 collisions: set and clear on the same cycle
        rx_full_set = 1; rx_data_rd = 1; tx_empty_set = 1; tx_data_wr = 1;
        rx_shift_set = 1; status_rd = 1; step(); idle_inputs();
        rx_data_rd = 1; tx_data_wr = 1; status_rd = 1; step(); idle_inputs();
        step();

        // R6/R7: DCD trips high, then line drops, flag held
        dcd_in = 1; step(); step();
        dcd_in = 0; step(); step();
        #1 chk("R7 dcd latched", {7'd0, status_out[6]}, 8'h01);
        // R8: acknowledge with condition still true keeps flag (low polarity now)
        dcd_pol_low = 1; ack_wr = 1; ack_wdata = 8'h40; step(); idle_inputs();
        #1 chk("R8 ack under condition", {7'd0, status_out[6]}, 8'h01);
        // flip polarity away and acknowledge: clears
        dcd_pol_low = 0; step();
        ack_wr = 1; ack_wdata = 8'h9F; step(); idle_inputs();   // R8 wrong bits ignored
        #1 chk("R8 other bits no effect", {7'd0, status_out[6]}, 8'h01);
        ack_wr = 1; ack_wdata = 8'h40; step(); idle_inputs();
        #1 chk("R8 dcd cleared", {7'd0, status_out[6]}, 8'h00);
        step();

        // R6 CTS with low polarity, R9 mask enables irq
        cts_pol_low = 1; cts_in = 1; mask_wr = 1; mask_wdata = 8'hFF; step(); idle_inputs();
        cts_in = 0; step(); step();
        cts_in = 1; cts_pol_low = 0; step();
        cts_pol_low = 1; ack_wr = 1; ack_wdata = 8'h20; step(); idle_inputs();
        step();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            cts_in       = ($urandom % 4) == 0 ? ~cts_in : cts_in;
            dcd_in       = ($urandom % 4) == 0 ? ~dcd_in : dcd_in;
            cts_pol_low  = ($urandom % 8) == 0 ? ~cts_pol_low : cts_pol_low;
            dcd_pol_low  = ($urandom % 8) == 0 ? ~dcd_pol_low : dcd_pol_low;
            mask_wr      = ($urandom % 10) == 0;
            mask_wdata   = 8'($urandom);
            ack_wr       = ($urandom % 3) == 0;
            ack_wdata    = 8'($urandom);
            status_rd    = ($urandom % 3) == 0;
            rx_full_set  = ($urandom % 3) == 0;
            rx_data_rd   = ($urandom % 3) == 0;
            tx_empty_set = ($urandom % 3) == 0;
            tx_data_wr   = ($urandom % 3) == 0;
            rx_shift_set = ($urandom % 3) == 0;
            step();
        end
        idle_inputs();
        step();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule